// File: doc/BRIEF.md
# Second-Level Address Translation Walker

This block turns a 48-bit guest-physical address into a host-physical address. It walks a four-level tree of tables held in memory. Every table is 4 KB and holds 512 eight-byte entries, so each level consumes nine address bits. A request carries the guest-physical address and a root pointer. The block then reads one entry per level through a simple read port, waiting for each entry's data before it forms the next address.

The walk normally ends at the bottom level with a 4 KB page. It ends one level early, with a 2 MB page, when the directory-level entry has its size bit set. Any entry whose three low bits are all zero is absent. The walk stops at that entry and reports a violation, along with the level where it stopped.

Only one translation is in flight at a time. The response is held until the consumer takes it.

Top module: `slat_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. It goes low in the cycle after a request is accepted and stays low until the response handshake (`rsp_valid && rsp_ready`) completes, after which it is high again.
- R2: The first read of a walk goes to address {12'h000, root[51:12], gpa[47:39], 3'b000}. Root bits 11:0 and 63:52 are ignored. Every read address has bits 63:52 and 2:0 equal to zero.
- R3: The second read uses bits 51:12 of the level-4 entry with index gpa[38:30]. The third read uses bits 51:12 of the level-3 entry with index gpa[29:21]. The index always sits in address bits 11:3.
- R4: The fourth read uses bits 51:12 of the directory (level-2) entry in address bits 51:12, and gpa[20:12] in address bits 11:3.
- R5: A walk that reaches a present level-1 entry responds with `rsp_pa` = {12'h000, entry[51:12], gpa[11:0]}, `rsp_large` = 0 and `rsp_fault` = 0.
- R6: A present directory entry with bit 7 set ends the walk after three reads. The response is `rsp_pa` = {12'h000, entry[51:21], gpa[20:0]}, `rsp_large` = 1 and `rsp_fault` = 0.
- R7: Bit 7 of the level-4 and level-3 entries has no effect. The walk continues to the next table.
- R8: An entry with bits 2:0 equal to 3'b000 ends the walk with no further reads. The response has `rsp_fault` = 1, `rsp_fault_level` set to the level number (4, 3, 2 or 1, as an unsigned 3-bit value), `rsp_pa` = 0 and `rsp_large` = 0.
- R9: Each read is a one-cycle `mem_req` pulse. `mem_addr` stays stable while the read waits. Exactly one read is issued per level visited, and the next read is issued only after `mem_rvalid` returns the previous entry.
- R10: While `rsp_valid` is high and `rsp_ready` is low, all response outputs hold their values.
- R11: After reset, `req_ready` = 1, `rsp_valid` = 0 and `mem_req` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_gpa | input | 48 | Guest-physical address to translate |
| req_root | input | 64 | Root table pointer; bits 51:12 are used |
| mem_req | output | 1 | One-cycle entry read strobe |
| mem_addr | output | 64 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry returned by memory |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa | output | 64 | Host-physical address, zero on violation |
| rsp_large | output | 1 | Translation is a 2 MB page |
| rsp_fault | output | 1 | Walk hit an absent entry |
| rsp_fault_level | output | 3 | Level (4..1) of the absent entry |

## Verification
The bench places an absent entry at each of the four levels. A design that kept walking past a zero entry would issue extra reads, and one that miscounted levels would report the wrong fault level.

The size bit is set in the level-4 and level-3 entries of a 4 KB mapping. A walker that honoured it there would stop early and return a large page.

The 2 MB case checks that the fourth read is skipped and that gpa bits 20:12 pass through. A design that merged bits at the 4 KB boundary would corrupt those bits.

Memory latency and response back-pressure are varied. A design that formed the next address before data arrived would read the wrong entry, and one that did not hold its response would drop or change the result.

// File: rtl/slat_pkg.sv
package slat_pkg;
  localparam int unsigned SLAT_LEVELS  = 4;
  localparam int unsigned SLAT_IDX_W   = 9;
  localparam int unsigned SLAT_OFF_W   = 12;
  localparam int unsigned SLAT_PA_W    = 52;
  localparam int unsigned SLAT_ENT_W   = 64;
  localparam int unsigned SLAT_LVL_W   = 3;
  localparam int unsigned SLAT_SIZE_BIT = 7;
  localparam int unsigned SLAT_DIR_LVL = 2;

  typedef enum logic [1:0] {
    WALK_IDLE,
    WALK_ISSUE,
    WALK_WAIT,
    WALK_RESP
  } walk_state_t;
endpackage

// File: rtl/slat_addr_gen.sv
module slat_addr_gen #(
  parameter int unsigned GPA_W   = 48,
  parameter int unsigned FRAME_W = 40,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned LEVELS  = 4,
  parameter int unsigned LVL_W   = 3
) (
  input  logic [FRAME_W-1:0] base,
  input  logic [GPA_W-1:0]   gpa,
  input  logic [LVL_W-1:0]   lvl,
  output logic [ADDR_W-1:0]  addr
);
  localparam int unsigned ENT_SH = OFF_W - IDX_W;
  localparam int unsigned TOP_W  = ADDR_W - FRAME_W - OFF_W;

  logic [IDX_W-1:0] idx_by_lvl [LEVELS];
  logic [IDX_W-1:0] idx;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_by_lvl[g] = gpa[OFF_W + IDX_W*g +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (lvl == LVL_W'(k + 1)) idx = idx_by_lvl[k];
    end
  end

  assign addr = {{TOP_W{1'b0}}, base, idx, {ENT_SH{1'b0}}};
endmodule

// File: rtl/slat_entry_decode.sv
module slat_entry_decode #(
  parameter int unsigned ENT_W    = 64,
  parameter int unsigned FRAME_W  = 40,
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned SIZE_BIT = 7
) (
  input  logic [ENT_W-1:0]   entry,
  output logic               present,
  output logic               size_flag,
  output logic [FRAME_W-1:0] frame
);
  assign present   = |entry[2:0];
  assign size_flag = entry[SIZE_BIT];
  assign frame     = entry[FRAME_W+OFF_W-1:OFF_W];
endmodule

// File: rtl/slat_walker.sv
module slat_walker
  import slat_pkg::*;
#(
  parameter int unsigned GPA_W  = 48,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned ENT_W  = SLAT_ENT_W,
  parameter int unsigned PA_W   = SLAT_PA_W,
  parameter int unsigned LVL_W  = SLAT_LVL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [GPA_W-1:0]  req_gpa,
  input  logic [ADDR_W-1:0] req_root,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ENT_W-1:0]  mem_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic              rsp_large,
  output logic              rsp_fault,
  output logic [LVL_W-1:0]  rsp_fault_level
);
  localparam int unsigned FRAME_W  = PA_W - SLAT_OFF_W;
  localparam int unsigned LARGE_SH = SLAT_OFF_W + SLAT_IDX_W;
  localparam int unsigned HI_W     = ADDR_W - PA_W;

  walk_state_t          state_q;
  logic [LVL_W-1:0]     lvl_q;
  logic [GPA_W-1:0]     gpa_q;
  logic [FRAME_W-1:0]   base_q;
  logic [ADDR_W-1:0]    next_addr;
  logic                 ent_present;
  logic                 ent_size;
  logic [FRAME_W-1:0]   ent_frame;
  logic [ADDR_W-1:0]    pa_small;
  logic [ADDR_W-1:0]    pa_large;

  slat_addr_gen #(
    .GPA_W(GPA_W), .FRAME_W(FRAME_W), .IDX_W(SLAT_IDX_W), .OFF_W(SLAT_OFF_W),
    .ADDR_W(ADDR_W), .LEVELS(SLAT_LEVELS), .LVL_W(LVL_W)
  ) u_addr_gen (
    .base(base_q), .gpa(gpa_q), .lvl(lvl_q), .addr(next_addr)
  );

  slat_entry_decode #(
    .ENT_W(ENT_W), .FRAME_W(FRAME_W), .OFF_W(SLAT_OFF_W), .SIZE_BIT(SLAT_SIZE_BIT)
  ) u_entry_decode (
    .entry(mem_rdata), .present(ent_present), .size_flag(ent_size), .frame(ent_frame)
  );

  assign pa_small = {{HI_W{1'b0}}, ent_frame, gpa_q[SLAT_OFF_W-1:0]};
  assign pa_large = {{HI_W{1'b0}}, mem_rdata[PA_W-1:LARGE_SH], gpa_q[LARGE_SH-1:0]};
  assign req_ready = (state_q == WALK_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q         <= WALK_IDLE;
      lvl_q           <= '0;
      gpa_q           <= '0;
      base_q          <= '0;
      mem_req         <= 1'b0;
      mem_addr        <= '0;
      rsp_valid       <= 1'b0;
      rsp_pa          <= '0;
      rsp_large       <= 1'b0;
      rsp_fault       <= 1'b0;
      rsp_fault_level <= '0;
    end else begin
      mem_req <= 1'b0;
      unique case (state_q)
        WALK_IDLE: begin
          if (req_valid) begin
            gpa_q   <= req_gpa;
            base_q  <= req_root[PA_W-1:SLAT_OFF_W];
            lvl_q   <= LVL_W'(SLAT_LEVELS);
            state_q <= WALK_ISSUE;
          end
        end
        WALK_ISSUE: begin
          mem_req  <= 1'b1;
          mem_addr <= next_addr;
          state_q  <= WALK_WAIT;
        end
        WALK_WAIT: begin
          if (mem_rvalid) begin
            if (!ent_present) begin
              rsp_valid       <= 1'b1;
              rsp_fault       <= 1'b1;
              rsp_fault_level <= lvl_q;
              rsp_pa          <= '0;
              rsp_large       <= 1'b0;
              state_q         <= WALK_RESP;
            end else if (lvl_q == LVL_W'(SLAT_DIR_LVL) && ent_size) begin
              rsp_valid       <= 1'b1;
              rsp_fault       <= 1'b0;
              rsp_fault_level <= '0;
              rsp_pa          <= pa_large;
              rsp_large       <= 1'b1;
              state_q         <= WALK_RESP;
            end else if (lvl_q == LVL_W'(1)) begin
              rsp_valid       <= 1'b1;
              rsp_fault       <= 1'b0;
              rsp_fault_level <= '0;
              rsp_pa          <= pa_small;
              rsp_large       <= 1'b0;
              state_q         <= WALK_RESP;
            end else begin
              base_q  <= ent_frame;
              lvl_q   <= lvl_q - LVL_W'(1);
              state_q <= WALK_ISSUE;
            end
          end
        end
        WALK_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state_q   <= WALK_IDLE;
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

  // R1: a request taken drops ready, and ready stays low while a response waits
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  assert_resp_busy_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  // R2: every read address is entry aligned and below the 52-bit limit
  assert_addr_format_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ADDR_W-1:PA_W] == '0 && mem_addr[2:0] == 3'b000));

  // R9: single-cycle strobe and stable address while waiting
  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> $stable(mem_addr));

  // R8: a violation carries no address, no size flag and a level in 1..4
  assert_fault_clean_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_pa == '0 && !rsp_large &&
      rsp_fault_level >= LVL_W'(1) && rsp_fault_level <= LVL_W'(SLAT_LEVELS)));

  // R10: a response not yet taken holds its value
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) &&
      $stable(rsp_large) && $stable(rsp_fault) && $stable(rsp_fault_level)));
endmodule

// File: tb/slat_walker_bench.sv
module slat_walker_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready;
  logic [47:0] req_gpa;
  logic [63:0] req_root;
  logic        mem_req, mem_rvalid;
  logic [63:0] mem_addr, mem_rdata;
  logic        rsp_valid, rsp_ready, rsp_large, rsp_fault;
  logic [63:0] rsp_pa;
  logic [2:0]  rsp_fault_level;

  always #5 clk = ~clk;

  slat_walker u_slat_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_gpa(req_gpa), .req_root(req_root), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_large(rsp_large),
    .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level)
  );

  logic [63:0] mem [logic [63:0]];
  int          checks = 0;
  int          errors = 0;
  int          rd_delay = 1;
  int          rd_cnt = 0;
  logic [63:0] rd_log [8];

  localparam logic [63:0] FRAME_MASK = 64'h000F_FFFF_FFFF_F000;
  localparam logic [63:0] ROOT_TBL   = 64'h0000_0000_0001_0000;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] slot(input logic [47:0] gpa, input int lvl);
    logic [8:0] ix;
    ix = 9'(gpa >> (12 + 9 * (lvl - 1)));
    return {52'h0, ix, 3'b000};
  endfunction

  function automatic logic [63:0] rd(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h0;
  endfunction

  // memory model: sample strobe at falling edge, answer after rd_delay cycles
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [63:0] a;
        a = mem_addr;
        if (rd_cnt < 8) rd_log[rd_cnt] = a;
        rd_cnt++;
        repeat (rd_delay) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = rd(a);
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
      end
    end
  end

  // places a chain of four entries following each entry's frame
  task automatic build(input logic [47:0] gpa, input logic [63:0] e4, input logic [63:0] e3,
                       input logic [63:0] e2, input logic [63:0] e1);
    mem.delete();
    mem[ROOT_TBL + slot(gpa, 4)]     = e4;
    mem[(e4 & FRAME_MASK) + slot(gpa, 3)] = e3;
    mem[(e3 & FRAME_MASK) + slot(gpa, 2)] = e2;
    mem[(e2 & FRAME_MASK) + slot(gpa, 1)] = e1;
  endtask

  // issues one request, holds the response hold_cyc cycles, compares to a reference walk
  task automatic walk(input string req, input logic [47:0] gpa, input int hold_cyc);
    logic [63:0] base, a, e, exp_pa;
    logic [63:0] exp_addr [4];
    logic        exp_large, exp_fault, done;
    logic [2:0]  exp_lvl;
    logic [63:0] got_pa;
    logic        got_large, got_fault;
    logic [2:0]  got_lvl;
    int          n;
    base = ROOT_TBL | 64'hFFF0_0000_0000_001E;
    exp_pa = '0; exp_large = 0; exp_fault = 0; exp_lvl = '0; done = 0; n = 0;
    base = base & FRAME_MASK;
    for (int lvl = 4; lvl >= 1 && !done; lvl--) begin
      a = base + slot(gpa, lvl);
      exp_addr[n] = a; n++;
      e = rd(a);
      if (e[2:0] == 3'b000) begin
        exp_fault = 1; exp_lvl = 3'(lvl); done = 1;
      end else if (lvl == 2 && e[7]) begin
        exp_pa = {12'h0, e[51:21], gpa[20:0]}; exp_large = 1; done = 1;
      end else if (lvl == 1) begin
        exp_pa = {12'h0, e[51:12], gpa[11:0]}; done = 1;
      end
      base = e & FRAME_MASK;
    end
    chk("R1", "ready before request", {63'h0, req_ready}, 64'h1);
    rd_cnt = 0;
    req_gpa = gpa;
    req_root = ROOT_TBL | 64'hFFF0_0000_0000_001E;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "ready after accept", {63'h0, req_ready}, 64'h0);
    for (int t = 0; t < 200 && !rsp_valid; t++) @(negedge clk);
    got_pa = rsp_pa; got_large = rsp_large; got_fault = rsp_fault; got_lvl = rsp_fault_level;
    for (int h = 0; h < hold_cyc; h++) begin
      @(negedge clk);
      chk("R10", "held pa", rsp_pa, got_pa);
      chk("R10", "held valid", {63'h0, rsp_valid}, 64'h1);
      chk("R1", "ready while held", {63'h0, req_ready}, 64'h0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R1", "ready after handshake", {63'h0, req_ready}, 64'h1);
    chk(req, "fault", {63'h0, got_fault}, {63'h0, exp_fault});
    chk(req, "fault level", {61'h0, got_fault ? got_lvl : 3'h0}, {61'h0, exp_lvl});
    chk(req, "pa", got_pa, exp_pa);
    chk(req, "large", {63'h0, got_large}, {63'h0, exp_large});
    chk("R9", "read count", 64'(rd_cnt), 64'(n));
    for (int i = 0; i < n && i < rd_cnt; i++)
      chk(i == 0 ? "R2" : (i == 3 ? "R4" : "R3"), "read address", rd_log[i], exp_addr[i]);
  endtask

  task automatic t_reset;
    chk("R11", "req_ready", {63'h0, req_ready}, 64'h1);
    chk("R11", "rsp_valid", {63'h0, rsp_valid}, 64'h0);
    chk("R11", "mem_req", {63'h0, mem_req}, 64'h0);
  endtask

  task automatic t_small_page;
    logic [47:0] g = 48'hA5C3_7E19_4D2B;
    build(g, 64'h0000_0000_0002_0007, 64'h0000_0000_0003_0003, 64'h0000_0000_0004_0001,
          64'h0007_3456_789A_B005);
    rd_delay = 0; walk("R5", g, 0);
    rd_delay = 2; walk("R5", 48'hA5C3_7E19_4FFF, 0);
  endtask

  task automatic t_large_page;
    logic [47:0] g = 48'h3F81_2B6D_E5A7;
    build(g, 64'h0000_0000_0002_0007, 64'h0000_0000_0003_0007, 64'h000A_BCDE_F120_0087,
          64'h0000_0000_0099_9007);
    rd_delay = 1; walk("R6", g, 0);
  endtask

  task automatic t_upper_size_bit;
    logic [47:0] g = 48'h0123_4567_89AB;
    build(g, 64'h0000_0000_0002_0087, 64'h0000_0000_0003_0087, 64'h0000_0000_0004_0007,
          64'h0001_2345_6789_0007);
    rd_delay = 1; walk("R7", g, 0);
  endtask

  task automatic t_absent;
    logic [47:0] g = 48'h7766_5544_3321;
    for (int lvl = 4; lvl >= 1; lvl--) begin
      build(g, lvl == 4 ? 64'h0000_0000_0002_0038 : 64'h0000_0000_0002_0007,
               lvl == 3 ? 64'h0000_0000_0003_0000 : 64'h0000_0000_0003_0007,
               lvl == 2 ? 64'h000F_0000_0004_0080 : 64'h0000_0000_0004_0007,
               lvl == 1 ? 64'h0005_5555_5555_5ff8 : 64'h0005_5555_5555_5007);
      rd_delay = lvl - 1; walk("R8", g, 0);
    end
  endtask

  task automatic t_backpressure;
    logic [47:0] g = 48'hFFFF_FFFF_FFFF;
    build(g, 64'h0000_0000_0002_0001, 64'h0000_0000_0003_0002, 64'h0000_0000_0004_0004,
          64'h000F_FFFF_FFFF_F004);
    rd_delay = 3; walk("R10", g, 4);
    build(g, 64'h0000_0000_0002_0001, 64'h0000_0000_0003_0002, 64'h000C_0000_0020_0084, 0);
    walk("R6", g, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_gpa = '0; req_root = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_small_page();
    t_large_page();
    t_upper_size_bit();
    t_absent();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule